// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an up/down timer/counter that produces a symmetric, phase-correct pulse-width-modulated waveform on a single compare output. An internal prescaler turns the system clock into a count enable, the "tick". On each tick the counter moves one step, rising from 0 to 255 and then falling back to 0. A full period is therefore 510 ticks, so the PWM frequency is f_clk / (N × 510), where N is the prescale ratio.

The compare value is written over a small register-write port into a buffer. That buffer is copied into the active compare register each time the counter turns at its top value, so a new duty cycle always starts on a period boundary. The waveform is cleared on a compare match while rising and set on a match while falling. At the top value the level is forced, which keeps the pulse centred on the bottom of the count. Two cases need this forcing: the compare value has just moved away from 255, or the counter was loaded above the compare value and so missed the rising match.

An invert input selects the polarity. A direction input decides whether the waveform drives the pin at all. An overflow flag and a compare-match flag are set by hardware and cleared by writing ones. The counter has two states: PH_RISE (counting up) and PH_FALL (counting down). PH_RISE moves to PH_FALL on a tick taken at 255. PH_FALL moves to PH_RISE on a tick taken at 0. A counter write never changes the state.

Top module: `pcpwm_timer`

## Requirements
- R1: A synchronous reset sets the count to 0 and the state to PH_RISE. It clears the compare buffer, the active compare value, both flags and the waveform level. The prescaler divider is also cleared.
- R2: presc_sel chooses the tick rate from a free-running 10-bit divider. Code 1 ticks on every clock. Codes 2, 3, 4 and 5 tick when the low 3, 6, 8 or 10 divider bits are all ones, giving ratios of 8, 64, 256 and 1024. Codes 0, 6 and 7 stop the counter.
- R3: On a tick, the counter steps by one in the direction of its state. A tick taken at 255 loads 254 and enters PH_FALL. A tick taken at 0 loads 1 and enters PH_RISE. The count is stable on cycles without a tick, so a period is 510 ticks.
- R4: A write with wr_addr = 0 stores wr_data in the compare buffer only. The active compare value takes the buffer contents on the tick taken at count 255.
- R5: At a tick where the count is strictly between 0 and 255 and equals the active compare value, the waveform level is cleared in PH_RISE and set in PH_FALL.
- R6: At a tick taken at count 0, the level is cleared if the active compare value is 0 and is otherwise unchanged. A compare value of 0 therefore gives a permanently low non-inverted output.
- R7: At a tick taken at count 255, the level is set if the buffered compare value is 255 and cleared otherwise. This holds whether or not a match happened while rising, so a compare value of 255 gives a permanently high output.
- R8: With invert = 1, the pin carries the complement of the waveform level.
- R9: pin_oe follows dir_out. While dir_out is 0, pin_out is 0.
- R10: A write with wr_addr = 1 loads wr_data into the counter and keeps the current state. On that cycle the tick's count step, compare action and flag setting are suppressed.
- R11: ovf_flag is set by a tick taken at count 0. It is cleared by a write with wr_addr = 2 and wr_data bit 0 = 1. A set in the same cycle wins over the clear.
- R12: cmp_flag is set by a tick taken when the count equals the active compare value, and shows on the clock after that tick. It is cleared by a write with wr_addr = 2 and wr_data bit 1 = 1. A set wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Prescaler ratio code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 compare buffer, 1 counter, 2 flag clear |
| wr_data | input | 8 | Write data |
| invert | input | 1 | Output polarity: 1 inverts |
| dir_out | input | 1 | Pin direction: 1 drives the waveform |
| pin_out | output | 1 | Gated PWM pin level |
| pin_oe | output | 1 | Pin output enable |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Bottom-reached flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
The count, the waveform level and both flags are registers. Each one changes at the clock edge that ends the tick cycle and can be seen one clock later. The polarity and pin gating are combinational and respond in the same cycle as their inputs. The bench runs a cycle-accurate reference in step with the design. It advances that reference at each rising edge using the inputs held over that edge. It then compares all outputs at the following falling edge, before it drives new inputs. At the slower ratios the comparison still happens on every clock, so a flag or step that arrived one divider position too early or too late is caught.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        WA_CMP  = 2'd0,
        WA_CNT  = 2'd1,
        WA_FLAG = 2'd2,
        WA_NONE = 2'd3
    } waddr_e;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_DIV1    = 3'd1,
        PS_DIV8    = 3'd2,
        PS_DIV64   = 3'd3,
        PS_DIV256  = 3'd4,
        PS_DIV1024 = 3'd5,
        PS_RSV6    = 3'd6,
        PS_RSV7    = 3'd7
    } psel_e;

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
    import pcpwm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam logic [DIV_W-1:0] MSK8    = DIV_W'(7);
    localparam logic [DIV_W-1:0] MSK64   = DIV_W'(63);
    localparam logic [DIV_W-1:0] MSK256  = DIV_W'(255);
    localparam logic [DIV_W-1:0] MSK1024 = DIV_W'(1023);

    logic [DIV_W-1:0] div_q;

    // Free-running divider shared by every ratio
    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + DIV_W'(1);
    end

    always_comb begin
        unique case (psel_e'(sel))
            PS_DIV1:    tick = 1'b1;
            PS_DIV8:    tick = ((div_q & MSK8)    == MSK8);
            PS_DIV64:   tick = ((div_q & MSK64)   == MSK64);
            PS_DIV256:  tick = ((div_q & MSK256)  == MSK256);
            PS_DIV1024: tick = ((div_q & MSK1024) == MSK1024);
            PS_OFF, PS_RSV6, PS_RSV7: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcpwm_updown.sv
module pcpwm_updown
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             rising
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOT = '0;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_RISE;
            cnt_q <= BOT;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state: a load keeps the phase, a tick steps or turns
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (load_en) begin
            cnt_d = load_val;
        end else if (tick) begin
            unique case (st_q)
                PH_RISE: begin
                    if (cnt_q == TOP) begin
                        st_d  = PH_FALL;
                        cnt_d = TOP - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                PH_FALL: begin
                    if (cnt_q == BOT) begin
                        st_d  = PH_RISE;
                        cnt_d = ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt    = cnt_q;
        rising = (st_q == PH_RISE);
    end
endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             rising,
    input  logic [CNT_W-1:0] cnt,
    input  logic             buf_we,
    input  logic [CNT_W-1:0] buf_din,
    output logic [CNT_W-1:0] buf_val,
    output logic             match,
    output logic             wave
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOT = '0;

    logic [CNT_W-1:0] buf_q, buf_d;
    logic [CNT_W-1:0] ocr_q, ocr_d;
    logic             wave_q, wave_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= BOT;
            ocr_q  <= BOT;
            wave_q <= 1'b0;
        end else begin
            buf_q  <= buf_d;
            ocr_q  <= ocr_d;
            wave_q <= wave_d;
        end
    end

    always_comb begin
        buf_d  = buf_we ? buf_din : buf_q;
        ocr_d  = ocr_q;
        wave_d = wave_q;
        if (step) begin
            if (cnt == TOP) begin
                // Turn point: reload and force the up-match level
                ocr_d  = buf_q;
                wave_d = (buf_q == TOP);
            end else if (cnt == BOT) begin
                if (ocr_q == BOT) wave_d = 1'b0;
            end else if (cnt == ocr_q) begin
                wave_d = !rising;
            end
        end
    end

    always_comb begin
        buf_val = buf_q;
        match   = (cnt == ocr_q);
        wave    = wave_q;
    end
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       presc_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             invert,
    input  logic             dir_out,
    output logic             pin_out,
    output logic             pin_oe,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             cmp_flag
);
    localparam logic [CNT_W-1:0] BOT = '0;

    logic             tick;
    logic             cnt_load;
    logic             buf_we;
    logic             flag_wr;
    logic             step;
    logic             rising;
    logic             match;
    logic             wave_lvl;
    logic [CNT_W-1:0] cmp_pend;
    logic             ovf_q, cmp_q;

    always_comb begin
        cnt_load = wr_en && (waddr_e'(wr_addr) == WA_CNT);
        buf_we   = wr_en && (waddr_e'(wr_addr) == WA_CMP);
        flag_wr  = wr_en && (waddr_e'(wr_addr) == WA_FLAG);
        step     = tick && !cnt_load;
    end

    pcpwm_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (presc_sel),
        .tick (tick)
    );

    pcpwm_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_en  (cnt_load),
        .load_val (wr_data),
        .cnt      (count),
        .rising   (rising)
    );

    pcpwm_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .rising  (rising),
        .cnt     (count),
        .buf_we  (buf_we),
        .buf_din (wr_data),
        .buf_val (cmp_pend),
        .match   (match),
        .wave    (wave_lvl)
    );

    // Flags: hardware set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            if (step && count == BOT)         ovf_q <= 1'b1;
            else if (flag_wr && wr_data[0])   ovf_q <= 1'b0;
            if (step && match)                cmp_q <= 1'b1;
            else if (flag_wr && wr_data[1])   cmp_q <= 1'b0;
        end
    end

    always_comb begin
        ovf_flag = ovf_q;
        cmp_flag = cmp_q;
        pin_oe   = dir_out;
        pin_out  = dir_out & (wave_lvl ^ invert);
    end
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cnt_load,
    input logic             rising,
    input logic             dir_out,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             ovf_flag,
    input logic             wave_lvl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp_pend
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOT = '0;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_load) |=> $stable(count));

    assert_rise_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && rising && count != TOP) |=> (count == $past(count) + ONE));

    assert_fall_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && !rising && count != BOT) |=> (count == $past(count) - ONE));

    assert_top_set_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && count == TOP && cmp_pend == TOP) |=> wave_lvl);

    assert_top_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && count == TOP && cmp_pend != TOP) |=> !wave_lvl);

    assert_pin_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !dir_out |-> (!pin_out && !pin_oe));

    assert_ovf_source_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(tick && !cnt_load && count == BOT));
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_load (cnt_load),
    .rising   (rising),
    .dir_out  (dir_out),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .ovf_flag (ovf_flag),
    .wave_lvl (wave_lvl),
    .count    (count),
    .cmp_pend (cmp_pend)
);

// File: tb/pcpwm_timer_test.sv
`timescale 1ns/1ps
module pcpwm_timer_test;
    logic       clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic [2:0] presc_sel;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       invert;
    logic       dir_out;
    logic       pin_out, pin_oe, ovf_flag, cmp_flag;
    logic [7:0] count;

    pcpwm_timer uut (
        .clk(clk), .rst(rst), .presc_sel(presc_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .invert(invert),
        .dir_out(dir_out), .pin_out(pin_out), .pin_oe(pin_oe),
        .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    // Reference state
    logic [9:0] m_div;
    logic [7:0] m_cnt, m_buf, m_ocr;
    bit         m_up, m_wave, m_ovf, m_cmp;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ref_tick(input logic [2:0] s, input logic [9:0] d);
        case (s)
            3'd1:    return 1'b1;
            3'd2:    return d[2:0] == 3'h7;
            3'd3:    return d[5:0] == 6'h3f;
            3'd4:    return d[7:0] == 8'hff;
            3'd5:    return d == 10'h3ff;
            default: return 1'b0;
        endcase
    endfunction

    task automatic m_step();
        logic [7:0] c, o, b;
        bit up, t, load, stp;
        bit ovf_s, cmp_s;
        if (rst) begin
            m_div = '0; m_cnt = '0; m_buf = '0; m_ocr = '0;
            m_up = 1'b1; m_wave = 1'b0; m_ovf = 1'b0; m_cmp = 1'b0;
        end else begin
            c = m_cnt; o = m_ocr; b = m_buf; up = m_up;
            t = ref_tick(presc_sel, m_div);
            load = wr_en && wr_addr == 2'd1;
            stp = t && !load;
            ovf_s = stp && c == 8'd0;
            cmp_s = stp && c == o;
            if (wr_en && wr_addr == 2'd0) m_buf = wr_data;
            if (load) m_cnt = wr_data;
            else if (t) begin
                if (up) begin
                    if (c == 8'd255) begin m_up = 1'b0; m_cnt = 8'd254; end
                    else m_cnt = c + 8'd1;
                end else begin
                    if (c == 8'd0) begin m_up = 1'b1; m_cnt = 8'd1; end
                    else m_cnt = c - 8'd1;
                end
                if (c == 8'd255) begin m_ocr = b; m_wave = (b == 8'd255); end
                else if (c == 8'd0) begin if (o == 8'd0) m_wave = 1'b0; end
                else if (c == o) m_wave = !up;
            end
            if (ovf_s) m_ovf = 1'b1;
            else if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_ovf = 1'b0;
            if (cmp_s) m_cmp = 1'b1;
            else if (wr_en && wr_addr == 2'd2 && wr_data[1]) m_cmp = 1'b0;
            m_div = m_div + 10'd1;
        end
    endtask

    task automatic cycle();
        bit ep;
        @(posedge clk);
        m_step();
        @(negedge clk);
        ep = dir_out ? (m_wave ^ invert) : 1'b0;
        chk(count == m_cnt, "R3 count", count, m_cnt);
        chk(pin_out == ep, "R5/R8 pin level", pin_out, ep);
        chk(pin_oe == dir_out, "R9 pin enable", pin_oe, dir_out);
        chk(ovf_flag == m_ovf, "R11 overflow flag", ovf_flag, m_ovf);
        chk(cmp_flag == m_cmp, "R12 compare flag", cmp_flag, m_cmp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) cycle();
    endtask

    initial begin
        #950000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n, hits;
        logic [7:0] last;
        void'($urandom(32'd20240611));
        rst = 1'b1; presc_sel = 3'd1; wr_en = 1'b0; wr_addr = 2'd0;
        wr_data = 8'd0; invert = 1'b0; dir_out = 1'b1;
        run(3);
        chk(count == 8'd0 && !ovf_flag && !cmp_flag && !pin_out, "R1 reset state",
            {ovf_flag, cmp_flag, pin_out}, 0);
        rst = 1'b0;

        // R4: buffered value does not act before the turn at 255
        wr(2'd0, 8'd100);
        wr(2'd2, 8'd3);
        while (m_cnt != 8'd150) cycle();
        chk(cmp_flag == 1'b0, "R4 buffer not yet active", cmp_flag, 0);

        // R3: overflow spacing equals one period
        while (!ovf_flag) cycle();
        wr(2'd2, 8'd1);
        n = 1;
        while (!ovf_flag) begin cycle(); n++; end
        chk(n == 510, "R3 period in ticks", n, 510);

        // R7 / R10: missed rising match forced at the turn
        while (!(m_up && m_cnt == 8'd50)) cycle();
        chk(pin_out == 1'b1, "R5 high around bottom", pin_out, 1);
        wr(2'd1, 8'd200);
        chk(count == 8'd200, "R10 counter loaded", count, 200);
        cycle();
        chk(count == 8'd201, "R10 direction kept", count, 201);
        while (!(!m_up && m_cnt == 8'd254)) cycle();
        chk(pin_out == 1'b0, "R7 forced low at turn", pin_out, 0);

        // R6: compare at bottom gives constant low
        wr(2'd0, 8'd0);
        run(600);
        hits = 0;
        for (int i = 0; i < 1020; i++) begin cycle(); if (pin_out) hits++; end
        chk(hits == 0, "R6 constant low", hits, 0);

        // R7: compare at top gives constant high; R8 inverts it
        wr(2'd0, 8'd255);
        run(600);
        hits = 0;
        for (int i = 0; i < 1020; i++) begin cycle(); if (!pin_out) hits++; end
        chk(hits == 0, "R7 constant high", hits, 0);
        invert = 1'b1;
        hits = 0;
        for (int i = 0; i < 520; i++) begin cycle(); if (pin_out) hits++; end
        chk(hits == 0, "R8 inverted constant", hits, 0);
        invert = 1'b0;

        // R9: pin disabled
        dir_out = 1'b0;
        hits = 0;
        for (int i = 0; i < 40; i++) begin cycle(); if (pin_out || pin_oe) hits++; end
        chk(hits == 0, "R9 pin off", hits, 0);
        dir_out = 1'b1;

        // R2: divide by 8 and by 64, then stopped
        presc_sel = 3'd2;
        cycle();
        last = count;
        while (count == last) cycle();
        last = count; n = 0;
        do begin cycle(); n++; end while (count == last);
        chk(n == 8, "R2 ratio 8 spacing", n, 8);
        presc_sel = 3'd3;
        last = count;
        while (count == last) cycle();
        last = count; n = 0;
        do begin cycle(); n++; end while (count == last);
        chk(n == 64, "R2 ratio 64 spacing", n, 64);
        presc_sel = 3'd0;
        last = count;
        run(100);
        chk(count == last, "R2 stopped", count, last);

        // R12: compare flag timing with ratio 8
        presc_sel = 3'd2;
        wr(2'd0, 8'd40);
        while (m_ocr != 8'd40) cycle();
        wr(2'd2, 8'd2);
        while (!cmp_flag) cycle();
        chk(count == 8'd41 || count == 8'd39, "R12 flag with step", count, 41);

        // Random phase
        for (int s = 0; s < 40; s++) begin
            presc_sel = ($urandom % 4 == 0) ? 3'd2 : 3'd1;
            if ($urandom % 5 == 0) begin
                rst = 1'b1; run(2); rst = 1'b0;
            end
            n = 100 + int'($urandom % 1500);
            for (int k = 0; k < n; k++) begin
                int r;
                logic [7:0] v;
                r = int'($urandom % 100);
                case ($urandom % 5)
                    0: v = 8'd0;
                    1: v = 8'd255;
                    2: v = 8'd1;
                    3: v = 8'd254;
                    default: v = 8'($urandom);
                endcase
                if (r < 3) wr(2'd0, v);
                else if (r < 5) wr(2'd1, 8'($urandom));
                else if (r < 8) wr(2'd2, 8'($urandom));
                else begin
                    if (r == 8) invert = ~invert;
                    if (r == 9) dir_out = ~dir_out;
                    cycle();
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule